// File: doc/BRIEF.md
# Paged Program Counter and Return Stack

This unit owns the program counter of a small microcontroller with 14-bit instruction words. Each clock cycle the external decoder presents one control operation and its operands (the immediate field of the instruction, the accumulator W and, for register writes, the data byte). On the next rising edge the unit moves the counter to the next fetch address. Software can see only the low byte of the counter, as a register. A separate page-latch register, which only software writes, supplies the upper counter bits for every transfer that does not carry a full address.

The unit handles sequential advance and skip, absolute jump and call with an 11-bit field, computed writes to the low byte, relative branches by a signed 9-bit literal or by W, and indirect calls through latch:W. Returns come from an 8-entry hardware stack, and return-from-interrupt also raises a one-cycle request to set the global interrupt enable. The stack is circular. It never signals overflow or underflow.

With default parameters the counter is 15 bits wide: the 7-bit page latch sits above the 8-bit low byte. An 11-bit absolute field covers one 2048-word page, and the top four latch bits select that page.

Top module: `prog_ctr_unit`

## Requirements
- R1: After reset `pc_o` is 0, `latch_o` is 0 and `gie_set_o` is 0.
- R2: Op 0 (step) loads pc+1 and op 1 (skip) loads pc+2, both modulo 2^15.
- R3: Op 4 (low-byte write) loads the counter with {latch_o[6:0], data_i[7:0]}. `pcl_o` always shows pc_o[7:0].
- R4: Op 2 (jump) loads {latch_o[6:3], lit_i[10:0]}.
- R5: Op 3 (call) pushes pc+1 and loads the same target as R4. Op 8 (return) loads the most recently pushed address and pops it.
- R6: Op 5 (branch) loads pc+1 plus lit_i[8:0] taken as two's complement.
- R7: Op 6 (branch by W) loads pc+1 plus w_i taken as unsigned.
- R8: Op 7 (call through W) pushes pc+1 and loads {latch_o[6:0], w_i}.
- R9: Op 9 (interrupt return) pops like op 8 and drives `gie_set_o` high for exactly the next cycle. No other op raises `gie_set_o`.
- R10: Op 10 loads the latch with lit_i[6:0] and op 11 loads it with data_i[6:0]; both also advance the counter by 1. No other op changes the latch.
- R11: The stack holds 8 entries in a ring. A ninth push overwrites the oldest entry. Each pop returns the entry below the ring pointer, so a pop past the last pushed entry returns whatever is left in the ring: the wrapped entry, or 0 after reset.
- R12: Op codes 12 to 15 behave as step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Counter operation code for this cycle |
| lit_i | input | 11 | Instruction immediate field |
| w_i | input | 8 | Accumulator value |
| data_i | input | 8 | Software write data for low byte or latch |
| pc_o | output | 15 | Program counter |
| pcl_o | output | 8 | Software-visible low byte of the counter |
| latch_o | output | 7 | Page latch register |
| gie_set_o | output | 1 | Pulse requesting global interrupt enable |

## Verification
The bench targets the page bits. A design that took the upper bits of a jump or a low-byte write from the old counter would land in the wrong page. It also checks that the latch does not move when the counter jumps, since a design that updated the latch from the counter would break the next partial transfer. Negative branch offsets and large unsigned W offsets catch sign-extension errors in either direction, and a jump to the top address followed by a step checks the wrap to zero. A nine-deep call chain unwound by nine returns exposes a stack that saturates or stalls instead of wrapping. A return straight after reset shows what an empty-ring pop yields. An interrupt return checks a gie pulse that lasts too long or that fires on a plain return.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [3:0] {
    OP_STEP   = 4'd0,
    OP_SKIP   = 4'd1,
    OP_JUMP   = 4'd2,
    OP_CALL   = 4'd3,
    OP_PCLWR  = 4'd4,
    OP_BRA    = 4'd5,
    OP_BRW    = 4'd6,
    OP_CALLW  = 4'd7,
    OP_RET    = 4'd8,
    OP_RETI   = 4'd9,
    OP_LATLIT = 4'd10,
    OP_LATWR  = 4'd11
  } pc_op_e;
endpackage

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_inc, ptr_dec;

  // ring pointer: no saturation, no error flag
  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign top_o   = mem_q[ptr_dec];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[ptr_q] <= push_val_i;
      ptr_q        <= ptr_inc;
    end else if (pop_i) begin
      ptr_q <= ptr_dec;
    end
  end

  p_push_top_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_val_i));
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int LAT_W = 7,
  parameter int JMP_W = 11,
  parameter int BR_W  = 9,
  parameter int DAT_W = 8
) (
  input  pc_op_e           op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LAT_W-1:0] latch_i,
  input  logic [JMP_W-1:0] lit_i,
  input  logic [DAT_W-1:0] w_i,
  input  logic [DAT_W-1:0] data_i,
  input  logic [PC_W-1:0]  top_i,
  output logic [PC_W-1:0]  nxt_o,
  output logic [PC_W-1:0]  ret_addr_o,
  output logic             push_o,
  output logic             pop_o
);
  localparam int HI_W  = PC_W - DAT_W;   // latch bits used above the low byte
  localparam int JHI_W = PC_W - JMP_W;   // latch bits used above an absolute field

  logic [PC_W-1:0] pc_inc, abs_tgt, pcl_tgt, w_tgt, bra_off, brw_off;

  assign pc_inc     = pc_i + 1'b1;
  assign ret_addr_o = pc_inc;
  assign pcl_tgt    = {latch_i[HI_W-1:0], data_i};
  assign w_tgt      = {latch_i[HI_W-1:0], w_i};
  assign bra_off    = {{(PC_W-BR_W){lit_i[BR_W-1]}}, lit_i[BR_W-1:0]};
  assign brw_off    = {{(PC_W-DAT_W){1'b0}}, w_i};

  generate
    if (JHI_W > 0) begin : g_paged
      assign abs_tgt = {latch_i[HI_W-1 -: JHI_W], lit_i};
    end else begin : g_flat
      assign abs_tgt = lit_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    nxt_o  = pc_inc;
    push_o = 1'b0;
    pop_o  = 1'b0;
    case (op_i)
      OP_SKIP:          nxt_o = pc_i + 2'd2;
      OP_JUMP:          nxt_o = abs_tgt;
      OP_CALL:          begin nxt_o = abs_tgt; push_o = 1'b1; end
      OP_PCLWR:         nxt_o = pcl_tgt;
      OP_BRA:           nxt_o = pc_inc + bra_off;
      OP_BRW:           nxt_o = pc_inc + brw_off;
      OP_CALLW:         begin nxt_o = w_tgt; push_o = 1'b1; end
      OP_RET, OP_RETI:  begin nxt_o = top_i; pop_o = 1'b1; end
      default:          nxt_o = pc_inc;
    endcase
  end
endmodule

// File: rtl/prog_ctr_unit.sv
module prog_ctr_unit
  import pc_pkg::*;
#(
  parameter int PC_W  = 15,
  parameter int LAT_W = 7,
  parameter int JMP_W = 11,
  parameter int BR_W  = 9,
  parameter int DAT_W = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       op_i,
  input  logic [JMP_W-1:0] lit_i,
  input  logic [DAT_W-1:0] w_i,
  input  logic [DAT_W-1:0] data_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [DAT_W-1:0] pcl_o,
  output logic [LAT_W-1:0] latch_o,
  output logic             gie_set_o
);
  localparam int JHI_W = PC_W - JMP_W;

  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_nxt, ret_addr, top;
  logic            push, pop;
  logic [LAT_W-1:0] latch_q;
  logic            gie_q;

  assign op = pc_op_e'(op_i);

  pc_next_calc #(
    .PC_W(PC_W), .LAT_W(LAT_W), .JMP_W(JMP_W), .BR_W(BR_W), .DAT_W(DAT_W)
  ) u_next (
    .op_i(op), .pc_i(pc_q), .latch_i(latch_q), .lit_i(lit_i), .w_i(w_i),
    .data_i(data_i), .top_i(top), .nxt_o(pc_nxt), .ret_addr_o(ret_addr),
    .push_o(push), .pop_o(pop)
  );

  pc_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_val_i(ret_addr), .top_o(top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      latch_q <= '0;
      gie_q   <= 1'b0;
    end else begin
      pc_q  <= pc_nxt;
      gie_q <= (op == OP_RETI);
      if (op == OP_LATLIT)     latch_q <= lit_i[LAT_W-1:0];
      else if (op == OP_LATWR) latch_q <= data_i[LAT_W-1:0];
    end
  end

  assign pc_o      = pc_q;
  assign pcl_o     = pc_q[DAT_W-1:0];
  assign latch_o   = latch_q;
  assign gie_set_o = gie_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd0) |=> pc_o == $past(pc_o) + 1'b1);
  p_latch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 4'd10 && op_i != 4'd11) |=> $stable(latch_o));
  p_jump_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd2) |=> pc_o[JMP_W-1:0] == $past(lit_i));
  p_pclwr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd4) |=> pcl_o == $past(data_i));
  p_gie_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_set_o |-> $past(op_i) == 4'd9);
  p_gie_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'd9) |=> gie_set_o);
  initial assert (JHI_W >= 0 && PC_W - DAT_W <= LAT_W);
endmodule

// File: tb/prog_ctr_unit_test.sv
module prog_ctr_unit_test;
  localparam int CLK_T = 10;
  localparam int NV    = 17;

  typedef struct packed {
    logic [3:0]  op;
    logic [10:0] lit;
    logic [7:0]  w;
    logic [7:0]  data;
    logic [14:0] exp_pc;
    logic [6:0]  exp_lat;
    logic        exp_gie;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd0,  11'h000, 8'h00, 8'h00, 15'h0001, 7'h00, 1'b0},  // R2 step
    '{4'd1,  11'h000, 8'h00, 8'h00, 15'h0003, 7'h00, 1'b0},  // R2 skip
    '{4'd10, 11'h02A, 8'h00, 8'h00, 15'h0004, 7'h2A, 1'b0},  // R10 latch lit
    '{4'd2,  11'h123, 8'h00, 8'h00, 15'h2923, 7'h2A, 1'b0},  // R4 jump
    '{4'd4,  11'h000, 8'h00, 8'h77, 15'h2A77, 7'h2A, 1'b0},  // R3 pcl write
    '{4'd5,  11'h1F0, 8'h00, 8'h00, 15'h2A68, 7'h2A, 1'b0},  // R6 bra -16
    '{4'd5,  11'h00F, 8'h00, 8'h00, 15'h2A78, 7'h2A, 1'b0},  // R6 bra +15
    '{4'd6,  11'h000, 8'hF0, 8'h00, 15'h2B69, 7'h2A, 1'b0},  // R7 brw
    '{4'd3,  11'h055, 8'h00, 8'h00, 15'h2855, 7'h2A, 1'b0},  // R5 call
    '{4'd7,  11'h000, 8'h10, 8'h00, 15'h2A10, 7'h2A, 1'b0},  // R8 callw
    '{4'd11, 11'h000, 8'h00, 8'hFF, 15'h2A11, 7'h7F, 1'b0},  // R10 latch write
    '{4'd8,  11'h000, 8'h00, 8'h00, 15'h2856, 7'h7F, 1'b0},  // R5 return
    '{4'd9,  11'h000, 8'h00, 8'h00, 15'h2B6A, 7'h7F, 1'b1},  // R9 reti
    '{4'd0,  11'h000, 8'h00, 8'h00, 15'h2B6B, 7'h7F, 1'b0},  // R9 pulse ends
    '{4'd2,  11'h7FF, 8'h00, 8'h00, 15'h7FFF, 7'h7F, 1'b0},  // R4 top page
    '{4'd0,  11'h000, 8'h00, 8'h00, 15'h0000, 7'h7F, 1'b0},  // R2 wrap
    '{4'd13, 11'h000, 8'h00, 8'h00, 15'h0001, 7'h7F, 1'b0}   // R12 unused op
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [10:0] lit_i = '0;
  logic [7:0]  w_i = '0, data_i = '0;
  logic [14:0] pc_o;
  logic [7:0]  pcl_o;
  logic [6:0]  latch_o;
  logic        gie_set_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk_i = ~clk_i;

  prog_ctr_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .lit_i(lit_i), .w_i(w_i),
    .data_i(data_i), .pc_o(pc_o), .pcl_o(pcl_o), .latch_o(latch_o),
    .gie_set_o(gie_set_o)
  );

  task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [10:0] lit,
                       input logic [7:0] w, input logic [7:0] d);
    op_i = op; lit_i = lit; w_i = w; data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    op_i = 4'd0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    op_i = 4'd0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R1 pc", pc_o, 15'h0);
    chk("R1 latch", {8'h0, latch_o}, 15'h0);
    chk("R1 gie", {14'h0, gie_set_o}, 15'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].lit, VECS[i].w, VECS[i].data);
      chk($sformatf("vec%0d pc", i), pc_o, VECS[i].exp_pc);
      chk($sformatf("vec%0d R3 pcl", i), {7'h0, pcl_o}, {7'h0, VECS[i].exp_pc[7:0]});
      chk($sformatf("vec%0d R10 latch", i), {8'h0, latch_o}, {8'h0, VECS[i].exp_lat});
      chk($sformatf("vec%0d R9 gie", i), {14'h0, gie_set_o}, {14'h0, VECS[i].exp_gie});
    end

    // R11: nine nested calls, then nine returns over a wrapped ring
    apply(4'd11, 11'h0, 8'h0, 8'h00);
    chk("R10 latch cleared", {8'h0, latch_o}, 15'h0);
    for (int k = 1; k <= 9; k++) begin
      apply(4'd3, 11'(k * 16), 8'h0, 8'h0);
      chk("R5 nested call", pc_o, 15'(k * 16));
    end
    for (int k = 9; k >= 2; k--) begin
      apply(4'd8, 11'h0, 8'h0, 8'h0);
      chk("R11 unwind", pc_o, 15'((k - 1) * 16 + 1));
    end
    apply(4'd8, 11'h0, 8'h0, 8'h0);
    chk("R11 pop past wrap", pc_o, 15'h081);
    chk("R9 no gie on ret", {14'h0, gie_set_o}, 15'h0);

    // R11: pop on a fresh ring
    do_reset();
    apply(4'd5, 11'h100, 8'h0, 8'h0);
    chk("R6 bra min", pc_o, 15'h7F01);
    apply(4'd8, 11'h0, 8'h0, 8'h0);
    chk("R11 empty pop", pc_o, 15'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule